// File: doc/BRIEF.md
# Two-Channel Interrupt Pending and Block Register

This block collects the interrupt request levels of two ATA channels. It keeps them in one byte-wide register that software can read and write, and drives a single level interrupt toward the host interrupt controller. For each channel, the register holds two bits:

- a pending bit, which follows the edges of that channel's request;
- a block bit, which stops a rising request from reaching the host line.

A blocked channel still records that it is pending. A falling request always pulls the host line low, whether or not the channel is blocked. Software clears pending bits by writing ones to their positions. Every write also reloads both block bits. If a write leaves a channel pending and unblocked, the host line is raised again.

The host line is a registered level. Only these forwarding events move it: a rising request, a falling request, and the re-raise after a write. Nothing else changes it. The read value is the live register contents.

Top module: `irq_status_reg`

## Requirements
- R1: After reset, the register reads 0x00 and the host line is low.
- R2: A rising request on channel 0 sets bit 2, and on channel 1 sets bit 3. The new value is visible one clock after the edge in which the request is first sampled high.
- R3: A falling request clears that channel's pending bit (bit 2 for channel 0, bit 3 for channel 1).
- R4: A rising request on a channel whose block bit is 0 drives the host line high.
- R5: A rising request on a blocked channel (bit 4 blocks channel 0, bit 5 blocks channel 1) still sets the pending bit and leaves the host line unchanged.
- R6: A falling request drives the host line low. This holds whatever the block bits are, and even if the other channel is still pending.
- R7: Writing 1 to bit 2 or bit 3 clears that pending bit, and writing 0 there leaves it unchanged. Clearing a pending bit does not lower the host line.
- R8: Every write loads bits 4 and 5 directly from the write data.
- R9: After a write, if any channel is still pending and its block bit is now 0, the host line is driven high. If no channel is pending and unblocked, the write leaves the host line unchanged.
- R10: Bits 0, 1, 6 and 7 always read 0, whatever value is written.
- R11: Within one clock, the write is applied first (pending clears, block load and re-raise). The channel 0 edge is applied next, and the channel 1 edge last, so a later event decides the host line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chReq | input | 2 | Request level from each channel (bit 0 is channel 0) |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrData | input | 8 | Write data |
| regValue | output | 8 | Current register contents |
| hostIrq | output | 1 | Level interrupt toward the host |

## Verification
A single unblocked request on its own shows that the pending bit and the host line follow both edges. A request raised while blocked, then unblocked by a write, tells a dropped interrupt apart from a held one that is re-raised later. Overlapping requests on both channels, with one of them falling, show that deassertion wins even with work still pending. Writes that land in the same cycle as request edges tell apart the order write-then-channel-0-then-channel-1 from any other order.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int NUM_CH   = 2;
  localparam int REG_W    = 8;
  localparam int PEND_LSB = 2;
  localparam int BLK_LSB  = 4;

  typedef struct packed {
    logic [NUM_CH-1:0] rise;
    logic [NUM_CH-1:0] fall;
    logic              wr;
    logic [NUM_CH-1:0] clrPend;
    logic [NUM_CH-1:0] blkLoad;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chReq,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  output ctrlStrobes_t      strobes
);
  logic [NUM_CH-1:0] reqQ;

  // One edge detector per channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) reqQ[c] <= 1'b0;
      else       reqQ[c] <= chReq[c];
    end
    assign strobes.rise[c] = chReq[c] & ~reqQ[c];
    assign strobes.fall[c] = ~chReq[c] & reqQ[c];
  end

  assign strobes.wr      = wrEn;
  assign strobes.clrPend = wrData[PEND_LSB +: NUM_CH] & {NUM_CH{wrEn}};
  assign strobes.blkLoad = wrData[BLK_LSB +: NUM_CH];
endmodule

// File: rtl/irq_stat_dpath.sv
module irq_stat_dpath
  import irq_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  output logic [REG_W-1:0] regValue,
  output logic             hostIrq
);
  logic [NUM_CH-1:0] pend, blk;
  logic [NUM_CH-1:0] pendNxt, blkNxt;
  logic              lineNxt;

  // Ordered evaluation: write first, then channel edges in index order
  always_comb begin
    pendNxt = pend;
    blkNxt  = blk;
    lineNxt = hostIrq;
    if (strobes.wr) begin
      pendNxt = pendNxt & ~strobes.clrPend;
      blkNxt  = strobes.blkLoad;
      if (|(pendNxt & ~blkNxt)) lineNxt = 1'b1;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (strobes.rise[c]) begin
        pendNxt[c] = 1'b1;
        if (!blkNxt[c]) lineNxt = 1'b1;
      end else if (strobes.fall[c]) begin
        pendNxt[c] = 1'b0;
        lineNxt    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend    <= '0;
      blk     <= '0;
      hostIrq <= 1'b0;
    end else begin
      pend    <= pendNxt;
      blk     <= blkNxt;
      hostIrq <= lineNxt;
    end
  end

  always_comb begin
    regValue = '0;
    regValue[PEND_LSB +: NUM_CH] = pend;
    regValue[BLK_LSB  +: NUM_CH] = blk;
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  chReq,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  regValue,
  output logic        hostIrq
);
  ctrlStrobes_t strobes;

  irq_stat_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .chReq   (chReq),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .strobes (strobes)
  );

  irq_stat_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regValue (regValue),
    .hostIrq  (hostIrq)
  );
endmodule

// File: rtl/irq_status_reg_chk.sv
module irq_status_reg_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] chReq,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] regValue,
  input logic       hostIrq
);
  logic [1:0] reqSeen;
  logic [1:0] up, dn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqSeen <= 2'b00;
    else       reqSeen <= chReq;
  end
  assign up = chReq & ~reqSeen;
  assign dn = ~chReq & reqSeen;

  // R2
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    up[0] |=> regValue[2]);

  // R3
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    dn[1] |=> !regValue[3]);

  // R6
  fall_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    dn[1] |=> !hostIrq);

  // R5
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostIrq && !wrEn && up == 2'b01 && dn == 2'b00 && regValue[4]) |=> !hostIrq);

  // R8
  blk_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> regValue[5:4] == $past(wrData[5:4]));

  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[2] && !up[0]) |=> !regValue[2]);

  // R10
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regValue[7:6] == 2'b00 && regValue[1:0] == 2'b00);

  // R4
  raise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostIrq) |-> ($past(wrEn) || $past(|up)));
endmodule

bind irq_status_reg irq_status_reg_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .chReq    (chReq),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .regValue (regValue),
  .hostIrq  (hostIrq)
);

// File: tb/sim_irq_status_reg.sv
`timescale 1ns/1ps
module sim_irq_status_reg;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] chReq = 2'b00;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] regValue;
  logic       hostIrq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_status_reg u0 (
    .clk(clk), .rstN(rstN), .chReq(chReq), .wrEn(wrEn),
    .wrData(wrData), .regValue(regValue), .hostIrq(hostIrq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=0x%02h exp=0x%02h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    tick();
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic setReq(input int ch, input logic v);
    chReq[ch] = v;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 value", regValue, 8'h00);
    chk("R1 line", {7'd0, hostIrq}, 8'h00);
    regWrite(8'hC3);
    chk("R10 reserved", regValue, 8'h00);
    chk("R10 line", {7'd0, hostIrq}, 8'h00);
  endtask

  task automatic t_unblocked();
    setReq(0, 1'b1);
    chk("R2 pend0", regValue, 8'h04);
    chk("R4 raise", {7'd0, hostIrq}, 8'h01);
    setReq(0, 1'b0);
    chk("R3 clear0", regValue, 8'h00);
    chk("R6 lower", {7'd0, hostIrq}, 8'h00);
  endtask

  task automatic t_blocked();
    regWrite(8'h10);
    chk("R8 block0", regValue, 8'h10);
    setReq(0, 1'b1);
    chk("R5 pend kept", regValue, 8'h14);
    chk("R5 line held", {7'd0, hostIrq}, 8'h00);
    regWrite(8'h00);
    chk("R8 unblock", regValue, 8'h04);
    chk("R9 reraise", {7'd0, hostIrq}, 8'h01);
    regWrite(8'h10);
    chk("R9 blocked write keeps line", {7'd0, hostIrq}, 8'h01);
    setReq(0, 1'b0);
    chk("R6 lower while blocked", {7'd0, hostIrq}, 8'h00);
    chk("R3 clear blocked", regValue, 8'h10);
    regWrite(8'h00);
  endtask

  task automatic t_w1c();
    setReq(1, 1'b1);
    chk("R2 pend1", regValue, 8'h08);
    chk("R4 raise ch1", {7'd0, hostIrq}, 8'h01);
    regWrite(8'h00);
    chk("R7 zero no effect", regValue, 8'h08);
    regWrite(8'h08);
    chk("R7 clear pend1", regValue, 8'h00);
    chk("R7 line unchanged", {7'd0, hostIrq}, 8'h01);
    setReq(1, 1'b0);
    chk("R6 lower ch1", {7'd0, hostIrq}, 8'h00);
    chk("R3 ch1 stays clear", regValue, 8'h00);
  endtask

  task automatic t_both();
    setReq(0, 1'b1);
    setReq(1, 1'b1);
    chk("R2 both pending", regValue, 8'h0C);
    setReq(1, 1'b0);
    chk("R6 lower with ch0 pending", {7'd0, hostIrq}, 8'h00);
    chk("R3 ch1 cleared only", regValue, 8'h04);
    regWrite(8'h00);
    chk("R9 reraise ch0", {7'd0, hostIrq}, 8'h01);
    setReq(0, 1'b0);
    chk("R6 final lower", {7'd0, hostIrq}, 8'h00);
  endtask

  task automatic t_same_cycle();
    wrEn = 1'b1; wrData = 8'h04; chReq[0] = 1'b1;
    tick();
    wrEn = 1'b0; wrData = 8'h00;
    chk("R11 edge after clear", regValue, 8'h04);
    chk("R11 edge raises", {7'd0, hostIrq}, 8'h01);
    setReq(0, 1'b0);
    wrEn = 1'b1; wrData = 8'h28; chReq[1] = 1'b1;
    tick();
    wrEn = 1'b0; wrData = 8'h00;
    chk("R11 block before edge", regValue, 8'h28);
    chk("R11 blocked edge no raise", {7'd0, hostIrq}, 8'h00);
    chReq = 2'b01;
    tick();
    chk("R11 ch order value", regValue, 8'h24);
    chk("R11 ch1 fall wins", {7'd0, hostIrq}, 8'h00);
    regWrite(8'h00);
    chk("R9 reraise after order", {7'd0, hostIrq}, 8'h01);
    setReq(0, 1'b0);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_unblocked();
    t_blocked();
    t_w1c();
    t_both();
    t_same_cycle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule